// File: doc/BRIEF.md
# Masked Pin Toggle Interrupt Detector

The block watches a group of general-purpose pins and raises one shared, sticky flag whenever a pin that is enabled in a per-pin mask changes level in either direction. Each pin is first captured and then resynchronised to the clock. The changes between successive synchronised samples are gated by the mask, and any surviving difference sets the flag. Software clears the flag with a one-cycle strobe. The interrupt request is the flag gated by a global enable.

A combinational wake output compares each raw pin with its first captured copy. It therefore signals a change on an enabled pin without waiting for a clock edge, and can restart a stopped clock. The pins are sampled whatever their drive direction, so a design can drive a pin itself to raise a software event.

Top module: `pin_toggle_irq`

## Requirements
- R1: While rst_ni is low, flag_o and irq_o are 0 and every pipeline stage holds 0. A pin held at 0 through reset release produces no flag.
- R2: With the clock running, a level change on pin i while mask_i[i]=1 sets flag_o after exactly three rising edges and not earlier. This holds for rising and falling changes alike.
- R3: A change on a pin whose mask bit is 0 never sets flag_o. Bit i of mask_i enables bit i of pin_i.
- R4: Changing mask_i while the pins are stable does not set flag_o, whatever the pin levels.
- R5: wake_o is combinational and equals the OR, over the pins with mask_i[i]=1, of pin_i[i] XOR that pin's first captured stage.
- R6: flag_o stays 1 until clr_i is sampled high. A clear with no new change pending drops flag_o at that edge.
- R7: When a change sets the flag at the same edge at which clr_i is high, flag_o is 1 after that edge.
- R8: irq_o equals flag_o AND enable_i. enable_i has no effect on flag_o.
- R9: Several enabled pins changing together set the single shared flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | N_PINS | Raw pin levels |
| mask_i | input | N_PINS | Per-pin enable, 1 = pin contributes |
| enable_i | input | 1 | Global interrupt enable |
| clr_i | input | 1 | Flag clear strobe |
| flag_o | output | 1 | Sticky pin-change flag |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Combinational wake request |

## Verification
A stage that holds a wrong value shows at flag_o. A change either appears at the wrong edge or never appears, and the latency check sees this within three cycles of the toggle. A stale first stage also shows at once on wake_o, which depends on it combinationally. A flag register that loses a set or a clear shows at the next sampled cycle. The random phase mixes mask edits, clears and toggles, so the masking and the priority between set and clear are exercised many times.

// File: rtl/ptd_pkg.sv
package ptd_pkg;
  parameter int unsigned PTD_DEF_PINS = 6;
  localparam int unsigned PTD_STAGES = 2; // capture + sync
endpackage

// File: rtl/ptd_capture.sv
module ptd_capture #(
  parameter int unsigned N_PINS = ptd_pkg::PTD_DEF_PINS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] cap_o,
  output logic [N_PINS-1:0] sync_o
);
  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    logic cap_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cap_q  <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        cap_q  <= pin_i[g];
        sync_q <= cap_q;
      end
    end
    assign cap_o[g]  = cap_q;
    assign sync_o[g] = sync_q;
  end
endmodule

// File: rtl/ptd_change.sv
module ptd_change #(
  parameter int unsigned N_PINS = ptd_pkg::PTD_DEF_PINS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] sync_i,
  input  logic [N_PINS-1:0] mask_i,
  output logic              set_o
);
  logic [N_PINS-1:0] prev_q;
  logic [N_PINS-1:0] cur_m, prev_m;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  // both sides gated by the same mask: a mask edit alone cannot differ
  assign cur_m  = sync_i & mask_i;
  assign prev_m = prev_q & mask_i;
  assign set_o  = |(cur_m ^ prev_m);
endmodule

// File: rtl/ptd_flag.sv
module ptd_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1; // set beats clear
    else if (clr_i) flag_q <= 1'b0;
  end
  assign flag_o = flag_q;
endmodule

// File: rtl/pin_toggle_irq.sv
module pin_toggle_irq #(
  parameter int unsigned N_PINS = ptd_pkg::PTD_DEF_PINS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_i,
  input  logic [N_PINS-1:0] mask_i,
  input  logic              enable_i,
  input  logic              clr_i,
  output logic              flag_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic [N_PINS-1:0] cap, sync;
  logic              set;

  ptd_capture #(.N_PINS(N_PINS)) u_capture (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .cap_o (cap),
    .sync_o(sync)
  );

  ptd_change #(.N_PINS(N_PINS)) u_change (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sync_i(sync),
    .mask_i(mask_i),
    .set_o (set)
  );

  ptd_flag u_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set),
    .clr_i (clr_i),
    .flag_o(flag_o)
  );

  // clockless path for wake-up
  assign wake_o = |((pin_i ^ cap) & mask_i);
  assign irq_o  = flag_o & enable_i;
endmodule

// File: rtl/pin_toggle_irq_chk.sv
module pin_toggle_irq_chk #(
  parameter int unsigned N_PINS = ptd_pkg::PTD_DEF_PINS
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_PINS-1:0] mask_i,
  input logic              enable_i,
  input logic              clr_i,
  input logic              flag_o,
  input logic              irq_o,
  input logic              wake_o,
  input logic              set
);
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set) |=> !flag_o);
  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set) |=> flag_o);
  a_r3_all_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && mask_i == '0) |=> !flag_o);
  a_r8_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !irq_o);
  a_r5_wake_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |-> !wake_o);
  always_comb begin
    if (!rst_ni) a_r1_reset: assert (!flag_o || $isunknown(flag_o));
  end
endmodule

bind pin_toggle_irq pin_toggle_irq_chk #(.N_PINS(N_PINS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mask_i  (mask_i),
  .enable_i(enable_i),
  .clr_i   (clr_i),
  .flag_o  (flag_o),
  .irq_o   (irq_o),
  .wake_o  (wake_o),
  .set     (set)
);

// File: tb/pin_toggle_irq_bench.sv
`timescale 1ns/1ps
module pin_toggle_irq_bench;
  localparam int N = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] pin = '0, mask = '0;
  logic en = 1'b0, clr = 1'b0;
  logic flag, irq, wake;
  int checks = 0, errors = 0;
  string req = "R1";

  // reference pipeline built from the requirements
  logic [N-1:0] p1, p2, p3;
  logic exp_flag;

  always #2 clk = ~clk;

  pin_toggle_irq #(.N_PINS(N)) u_pin_toggle_irq (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .mask_i(mask),
    .enable_i(en), .clr_i(clr), .flag_o(flag), .irq_o(irq), .wake_o(wake)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1 <= '0; p2 <= '0; p3 <= '0; exp_flag <= 1'b0;
    end else begin
      p1 <= pin; p2 <= p1; p3 <= p2;
      exp_flag <= (|((p2 ^ p3) & mask)) | (exp_flag & ~clr);
    end
  end

  function automatic logic exp_wake();
    return |((pin ^ p1) & mask);
  endfunction

  task automatic chk(string r, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", r, what, act, exp);
    end
  endtask

  // one cycle: edge, then compare all outputs at the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk(req, "flag", flag, exp_flag);
    chk("R8", "irq", irq, exp_flag & en);
    chk("R5", "wake", wake, exp_wake());
  endtask

  task automatic drive(logic [N-1:0] p, logic [N-1:0] m, logic e, logic c);
    pin = p; mask = m; en = e; clr = c;
    #0.5;
    chk("R5", "wake_comb", wake, exp_wake());
  endtask

  task automatic settle_clear();
    drive(pin, mask, en, 1'b1);
    repeat (4) step();
    drive(pin, mask, en, 1'b0);
    step();
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    #1;
    chk("R1", "flag_rst", flag, 1'b0);
    chk("R1", "irq_rst", irq, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    req = "R1";
    repeat (3) step();

    // R2: rising change on pin 0, exact latency
    req = "R2";
    @(negedge clk);
    drive('0, '1, 1'b1, 1'b0);
    drive(6'b000001, '1, 1'b1, 1'b0);
    step(); chk("R2", "lat1", flag, 1'b0);
    step(); chk("R2", "lat2", flag, 1'b0);
    step(); chk("R2", "lat3", flag, 1'b1);
    chk("R8", "irq_on", irq, 1'b1);
    // R6: sticky then clear
    req = "R6";
    repeat (3) step();
    chk("R6", "sticky", flag, 1'b1);
    drive(pin, mask, 1'b1, 1'b1);
    step(); chk("R6", "cleared", flag, 1'b0);
    drive(pin, mask, 1'b1, 1'b0);
    // R2: falling change on pin 5 (after raising it)
    req = "R2";
    drive(6'b100001, '1, 1'b1, 1'b0);
    repeat (4) step();
    settle_clear();
    drive(6'b000001, '1, 1'b1, 1'b0);
    step(); step(); chk("R2", "fall_lat2", flag, 1'b0);
    step(); chk("R2", "fall_lat3", flag, 1'b1);
    settle_clear();

    // R3: masked pin 2 toggles
    req = "R3";
    drive(pin ^ 6'b000100, ~6'b000100, 1'b1, 1'b0);
    repeat (5) step();
    chk("R3", "masked", flag, 1'b0);

    // R4: mask edits with pins high
    req = "R4";
    drive('1, '0, 1'b1, 1'b0);
    repeat (5) step();
    for (int k = 0; k < 8; k++) begin
      drive(pin, 6'($urandom), 1'b1, 1'b0);
      step();
    end
    chk("R4", "mask_edit", flag, 1'b0);

    // R7: clear coincides with set edge
    req = "R7";
    drive('0, '1, 1'b1, 1'b0);
    step(); step();
    drive(pin, mask, 1'b1, 1'b1);
    step(); chk("R7", "set_wins", flag, 1'b1);
    drive(pin, mask, 1'b1, 1'b0);

    // R8: enable off keeps flag
    req = "R8";
    drive(pin, mask, 1'b0, 1'b0);
    step();
    chk("R8", "irq_off", irq, 1'b0);
    chk("R8", "flag_kept", flag, 1'b1);
    settle_clear();

    // R9: several pins together
    req = "R9";
    drive(6'b101010, '1, 1'b1, 1'b0);
    repeat (3) step();
    chk("R9", "multi", flag, 1'b1);
    settle_clear();

    // random mix
    req = "R2";
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] p;
      p = pin;
      if ($urandom_range(3) == 0) p = p ^ (6'b1 << $urandom_range(N - 1));
      drive(p, ($urandom_range(7) == 0) ? 6'($urandom) : mask,
            1'($urandom), ($urandom_range(4) == 0));
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule